// File: doc/BRIEF.md
# Execute Redirect Arbiter

This block sits at the end of the execute stage of a multi-threaded out-of-order core. Each cycle it receives up to `W` executed instructions in age order, with slot 0 the oldest. Each slot carries a thread id, a sequence number, its own PC and the PC that follows it, the predicted direction, and three event flags: branch mispredict, memory-ordering violation and load blocked by memory. Other logic detects these events. For each thread the block picks the single oldest instruction that raises an event and turns it into one squash record for the commit stage.

Each cause uses its own restart rule. A branch mispredict restarts at the resolved next PC and keeps the branch itself. An ordering violation also restarts at the next PC. A blocked load restarts at the load's own PC and squashes the load too. After a blocked-load squash, that thread ignores further blocked-load events until the load/store queue re-arms it. Two wrapping counters accumulate the branch squashes that were acted on, one for predicted taken and one for predicted not taken. Slots already marked squashed are reported as done and cannot redirect.

Top module: `redir_arb`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: For each thread, only the lowest-index qualifying slot with that thread id (the oldest) produces a squash in a given cycle. Threads are resolved independently, so several threads may squash in the same cycle.
- R3: Within one slot the cause precedence is mispredict first, then ordering violation, then blocked load. A blocked load qualifies only while the thread's `blk_handled` bit is 0.
- R4: A branch squash sets `sq_seq` to the slot's sequence number, `sq_next_pc` to its next PC, `sq_mis_pc` to its PC and `sq_branch` to 1, and clears `sq_incl`. `sq_taken` is 1 exactly when next PC differs from PC + `ISZ` (default 4), computed modulo 2^16.
- R5: An ordering squash sets `sq_seq` and `sq_next_pc` from the slot. It clears `sq_mis_pc`, `sq_branch`, `sq_taken` and `sq_incl`.
- R6: A blocked-load squash sets `sq_seq`, sets `sq_next_pc` to the slot's own PC, sets `sq_incl` to 1 and sets that thread's `blk_handled`. `blk_handled` stays set until a cycle with `blk_rearm[t]`=1 and no new blocked-load squash for that thread clears it.
- R7: Each branch squash acted on increments `cnt_taken_wrong` when its predicted-taken bit is 1, and `cnt_ntaken_wrong` otherwise. Both counters wrap at 2^`CNT_W`.
- R8: A slot with both `ex_valid` and `ex_squashed` set raises `ex_done` for that slot on the next cycle and never causes a squash, whatever its event flags.
- R9: Squash outputs are registered with one cycle of latency. When `sq_valid[t]` is 0, every other squash field of thread t is 0.
- R10: Slots with `ex_valid`=0 affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | W | Slot holds an instruction |
| ex_squashed | input | W | Instruction already squashed |
| ex_tid | input | W x TID_W | Thread id per slot |
| ex_seq | input | W x 8 | Sequence number per slot |
| ex_pc | input | W x 16 | Instruction PC per slot |
| ex_npc | input | W x 16 | Resolved next PC per slot |
| ex_pred_taken | input | W | Branch was predicted taken |
| ex_mispred | input | W | Branch mispredict event |
| ex_ord_viol | input | W | Memory-ordering violation event |
| ex_mem_blocked | input | W | Load blocked by memory event |
| blk_rearm | input | T | Clear a thread's blocked-load handled bit |
| sq_valid | output | T | Squash issued for the thread |
| sq_seq | output | T x 8 | Sequence number of the triggering instruction |
| sq_next_pc | output | T x 16 | Restart PC |
| sq_mis_pc | output | T x 16 | PC of the mispredicted branch |
| sq_branch | output | T | Squash is a branch mispredict |
| sq_taken | output | T | Resolved branch direction was taken |
| sq_incl | output | T | Triggering instruction is squashed as well |
| blk_handled | output | T | Blocked-load squash already issued |
| ex_done | output | W | Squashed slot marked executed and commit-ready |
| cnt_taken_wrong | output | CNT_W | Predicted-taken mispredict count |
| cnt_ntaken_wrong | output | CNT_W | Predicted-not-taken mispredict count |

## Verification
The properties assume that slot thread ids are always below `T`. They also assume that an event flag on an invalid or squashed slot carries no meaning. The counter-step property relies on each thread contributing at most one branch squash per cycle. The stimulus therefore draws thread ids only from 0 to T-1, and sets event flags freely on invalid and squashed slots so that the block has to show it ignores them. Stimulus changes on the falling edge, so the registered outputs and the handled bits are always sampled one full cycle after the inputs that produced them.

// File: rtl/redir_pkg.sv
package redir_pkg;

    localparam int SEQ_W = 8;
    localparam int PC_W  = 16;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_BRANCH = 2'd1,
        CAUSE_ORDER  = 2'd2,
        CAUSE_MEMBLK = 2'd3
    } cause_e;

    typedef struct packed {
        logic             vld;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  npc;
        logic [PC_W-1:0]  mpc;
        logic             brmis;
        logic             taken;
        logic             incl;
    } sq_rec_t;

    // Cause precedence: mispredict, ordering violation, then an armed blocked load.
    function automatic cause_e classify(input logic live, input logic mis,
                                        input logic ord, input logic blk,
                                        input logic armed);
        if (!live)              return CAUSE_NONE;
        else if (mis)           return CAUSE_BRANCH;
        else if (ord)           return CAUSE_ORDER;
        else if (blk && armed)  return CAUSE_MEMBLK;
        else                    return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/redir_slot_eval.sv
module redir_slot_eval
    import redir_pkg::*;
#(
    parameter int ISZ = 4
) (
    input  logic             live,
    input  logic             mis,
    input  logic             ord,
    input  logic             blk,
    input  logic             armed,
    input  logic [SEQ_W-1:0] seq,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  npc,
    output cause_e           cause,
    output sq_rec_t          rec
);
    localparam logic [PC_W-1:0] STEP = PC_W'(ISZ);

    always_comb begin
        cause = classify(live, mis, ord, blk, armed);
        rec   = '0;
        unique case (cause)
            CAUSE_BRANCH: begin
                rec.vld   = 1'b1;
                rec.seq   = seq;
                rec.npc   = npc;
                rec.mpc   = pc;
                rec.brmis = 1'b1;
                rec.taken = (npc != (pc + STEP));
            end
            CAUSE_ORDER: begin
                rec.vld = 1'b1;
                rec.seq = seq;
                rec.npc = npc;
            end
            CAUSE_MEMBLK: begin
                rec.vld  = 1'b1;
                rec.seq  = seq;
                rec.npc  = pc;
                rec.incl = 1'b1;
            end
            default: rec = '0;
        endcase
    end
endmodule

// File: rtl/redir_thread_pick.sv
module redir_thread_pick
    import redir_pkg::*;
#(
    parameter int W     = 4,
    parameter int TID_W = 1,
    parameter int TID   = 0
) (
    input  logic [W-1:0][TID_W-1:0] tid,
    input  cause_e [W-1:0]          cause,
    input  sq_rec_t [W-1:0]         rec,
    input  logic [W-1:0]            pred,
    output sq_rec_t                 pick,
    output logic                    blk_set,
    output logic                    br_fire,
    output logic                    br_pred
);
    localparam logic [TID_W-1:0] MY_TID = TID_W'(TID);

    always_comb begin
        logic found;
        found   = 1'b0;
        pick    = '0;
        blk_set = 1'b0;
        br_fire = 1'b0;
        br_pred = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!found && tid[i] == MY_TID && cause[i] != CAUSE_NONE) begin
                found   = 1'b1;
                pick    = rec[i];
                blk_set = (cause[i] == CAUSE_MEMBLK);
                br_fire = (cause[i] == CAUSE_BRANCH);
                br_pred = pred[i];
            end
        end
    end
endmodule

// File: rtl/redir_mis_cnt.sv
module redir_mis_cnt #(
    parameter int T     = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [T-1:0]     inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] add;

    always_comb begin
        add = '0;
        for (int t = 0; t < T; t++) add = add + CNT_W'(inc[t]);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + add;
    end
endmodule

// File: rtl/redir_arb.sv
module redir_arb
    import redir_pkg::*;
#(
    parameter int W     = 4,
    parameter int T     = 2,
    parameter int ISZ   = 4,
    parameter int CNT_W = 8,
    localparam int TID_W = (T > 1) ? $clog2(T) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [W-1:0]            ex_valid,
    input  logic [W-1:0]            ex_squashed,
    input  logic [W-1:0][TID_W-1:0] ex_tid,
    input  logic [W-1:0][SEQ_W-1:0] ex_seq,
    input  logic [W-1:0][PC_W-1:0]  ex_pc,
    input  logic [W-1:0][PC_W-1:0]  ex_npc,
    input  logic [W-1:0]            ex_pred_taken,
    input  logic [W-1:0]            ex_mispred,
    input  logic [W-1:0]            ex_ord_viol,
    input  logic [W-1:0]            ex_mem_blocked,
    input  logic [T-1:0]            blk_rearm,
    output logic [T-1:0]            sq_valid,
    output logic [T-1:0][SEQ_W-1:0] sq_seq,
    output logic [T-1:0][PC_W-1:0]  sq_next_pc,
    output logic [T-1:0][PC_W-1:0]  sq_mis_pc,
    output logic [T-1:0]            sq_branch,
    output logic [T-1:0]            sq_taken,
    output logic [T-1:0]            sq_incl,
    output logic [T-1:0]            blk_handled,
    output logic [W-1:0]            ex_done,
    output logic [CNT_W-1:0]        cnt_taken_wrong,
    output logic [CNT_W-1:0]        cnt_ntaken_wrong
);
    cause_e  [W-1:0] slot_cause;
    sq_rec_t [W-1:0] slot_rec;
    sq_rec_t [T-1:0] pick_rec;
    sq_rec_t [T-1:0] rec_q;
    logic    [T-1:0] blk_set, br_fire, br_pred;
    logic    [T-1:0] handled_q;

    for (genvar i = 0; i < W; i++) begin : g_slot
        redir_slot_eval #(.ISZ(ISZ)) u_eval (
            .live  (ex_valid[i] && !ex_squashed[i]),
            .mis   (ex_mispred[i]),
            .ord   (ex_ord_viol[i]),
            .blk   (ex_mem_blocked[i]),
            .armed (!handled_q[ex_tid[i]]),
            .seq   (ex_seq[i]),
            .pc    (ex_pc[i]),
            .npc   (ex_npc[i]),
            .cause (slot_cause[i]),
            .rec   (slot_rec[i])
        );
    end

    for (genvar t = 0; t < T; t++) begin : g_thr
        redir_thread_pick #(.W(W), .TID_W(TID_W), .TID(t)) u_pick (
            .tid     (ex_tid),
            .cause   (slot_cause),
            .rec     (slot_rec),
            .pred    (ex_pred_taken),
            .pick    (pick_rec[t]),
            .blk_set (blk_set[t]),
            .br_fire (br_fire[t]),
            .br_pred (br_pred[t])
        );

        assign sq_valid[t]   = rec_q[t].vld;
        assign sq_seq[t]     = rec_q[t].seq;
        assign sq_next_pc[t] = rec_q[t].npc;
        assign sq_mis_pc[t]  = rec_q[t].mpc;
        assign sq_branch[t]  = rec_q[t].brmis;
        assign sq_taken[t]   = rec_q[t].taken;
        assign sq_incl[t]    = rec_q[t].incl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q     <= '0;
            handled_q <= '0;
            ex_done   <= '0;
        end else begin
            rec_q     <= pick_rec;
            handled_q <= (handled_q & ~blk_rearm) | blk_set;
            ex_done   <= ex_valid & ex_squashed;
        end
    end

    assign blk_handled = handled_q;

    redir_mis_cnt #(.T(T), .CNT_W(CNT_W)) u_cnt_tw (
        .clk (clk), .rst (rst), .inc (br_fire & br_pred), .cnt (cnt_taken_wrong)
    );
    redir_mis_cnt #(.T(T), .CNT_W(CNT_W)) u_cnt_nw (
        .clk (clk), .rst (rst), .inc (br_fire & ~br_pred), .cnt (cnt_ntaken_wrong)
    );
endmodule

// File: rtl/redir_arb_chk.sv
module redir_arb_chk
    import redir_pkg::*;
#(
    parameter int W     = 4,
    parameter int T     = 2,
    parameter int ISZ   = 4,
    parameter int CNT_W = 8,
    localparam int TID_W = (T > 1) ? $clog2(T) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [W-1:0]            ex_valid,
    input logic [W-1:0]            ex_squashed,
    input logic [W-1:0][TID_W-1:0] ex_tid,
    input logic [W-1:0][SEQ_W-1:0] ex_seq,
    input logic [W-1:0][PC_W-1:0]  ex_pc,
    input logic [W-1:0][PC_W-1:0]  ex_npc,
    input logic [W-1:0]            ex_pred_taken,
    input logic [W-1:0]            ex_mispred,
    input logic [W-1:0]            ex_ord_viol,
    input logic [W-1:0]            ex_mem_blocked,
    input logic [T-1:0]            blk_rearm,
    input logic [T-1:0]            sq_valid,
    input logic [T-1:0][SEQ_W-1:0] sq_seq,
    input logic [T-1:0][PC_W-1:0]  sq_next_pc,
    input logic [T-1:0][PC_W-1:0]  sq_mis_pc,
    input logic [T-1:0]            sq_branch,
    input logic [T-1:0]            sq_taken,
    input logic [T-1:0]            sq_incl,
    input logic [T-1:0]            blk_handled,
    input logic [W-1:0]            ex_done,
    input logic [CNT_W-1:0]        cnt_taken_wrong,
    input logic [CNT_W-1:0]        cnt_ntaken_wrong
);
    for (genvar t = 0; t < T; t++) begin : g_t
        // R4: a branch squash never takes the branch itself with it
        assert_branch_not_incl_R4: assert property (@(posedge clk) disable iff (rst)
            (sq_valid[t] && sq_branch[t]) |-> !sq_incl[t]);

        // R9: idle record fields are zero
        assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
            !sq_valid[t] |-> (sq_seq[t] == '0 && sq_next_pc[t] == '0 &&
                              sq_mis_pc[t] == '0 && !sq_branch[t] &&
                              !sq_taken[t] && !sq_incl[t]));

        // R2: a squash needs a live instruction in the previous cycle
        assert_needs_live_R2: assert property (@(posedge clk) disable iff (rst)
            sq_valid[t] |-> $past(|(ex_valid & ~ex_squashed)));

        // R6: the handled bit only rises with an inclusive squash
        assert_handled_rise_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(blk_handled[t]) |-> (sq_valid[t] && sq_incl[t]));
    end

    // R7: counters advance by at most one per thread per cycle
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(CNT_W'(cnt_taken_wrong - $past(cnt_taken_wrong))) +
         32'(CNT_W'(cnt_ntaken_wrong - $past(cnt_ntaken_wrong)))) <= 32'(T));
endmodule

bind redir_arb redir_arb_chk #(.W(W), .T(T), .ISZ(ISZ), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_redir_arb.sv
`timescale 1ns/1ps
module tb_redir_arb;
    import redir_pkg::*;

    localparam int W = 4, T = 2, ISZ = 4, CNT_W = 8, TID_W = 1;

    logic clk = 1'b0, rst = 1'b1;
    logic [W-1:0]            ex_valid, ex_squashed, ex_pred_taken, ex_mispred, ex_ord_viol, ex_mem_blocked;
    logic [W-1:0][TID_W-1:0] ex_tid;
    logic [W-1:0][SEQ_W-1:0] ex_seq;
    logic [W-1:0][PC_W-1:0]  ex_pc, ex_npc;
    logic [T-1:0]            blk_rearm;
    logic [T-1:0]            sq_valid, sq_branch, sq_taken, sq_incl, blk_handled;
    logic [T-1:0][SEQ_W-1:0] sq_seq;
    logic [T-1:0][PC_W-1:0]  sq_next_pc, sq_mis_pc;
    logic [W-1:0]            ex_done;
    logic [CNT_W-1:0]        cnt_taken_wrong, cnt_ntaken_wrong;

    redir_arb #(.W(W), .T(T), .ISZ(ISZ), .CNT_W(CNT_W)) dut (.*);

    always #2 clk = ~clk;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [T-1:0]     m_hd = '0;
    logic [CNT_W-1:0] m_tw = '0, m_nw = '0;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        ex_valid = '0; ex_squashed = '0; ex_pred_taken = '0; ex_mispred = '0;
        ex_ord_viol = '0; ex_mem_blocked = '0; ex_tid = '0; ex_seq = '0;
        ex_pc = '0; ex_npc = '0; blk_rearm = '0;
    endtask

    task automatic put(int i, int tid, int seq, int pc, int npc, bit pt,
                       bit mis, bit ord, bit blk, bit sqd);
        ex_valid[i] = 1'b1; ex_squashed[i] = sqd; ex_tid[i] = TID_W'(tid);
        ex_seq[i] = SEQ_W'(seq); ex_pc[i] = PC_W'(pc); ex_npc[i] = PC_W'(npc);
        ex_pred_taken[i] = pt; ex_mispred[i] = mis; ex_ord_viol[i] = ord;
        ex_mem_blocked[i] = blk;
    endtask

    // Inputs are already driven (at a falling edge); compute, clock, compare.
    task automatic step(string tag);
        sq_rec_t    e [T];
        logic [T-1:0] set;
        logic [W-1:0] e_done;
        set = '0;
        for (int t = 0; t < T; t++) begin
            bit found = 0;
            e[t] = '0;
            for (int i = 0; i < W; i++) begin
                if (!found && ex_valid[i] && !ex_squashed[i] && int'(ex_tid[i]) == t) begin
                    if (ex_mispred[i]) begin
                        found = 1; e[t].vld = 1; e[t].seq = ex_seq[i]; e[t].npc = ex_npc[i];
                        e[t].mpc = ex_pc[i]; e[t].brmis = 1;
                        e[t].taken = (ex_npc[i] != PC_W'(ex_pc[i] + 16'd4));
                        if (ex_pred_taken[i]) m_tw++; else m_nw++;
                    end else if (ex_ord_viol[i]) begin
                        found = 1; e[t].vld = 1; e[t].seq = ex_seq[i]; e[t].npc = ex_npc[i];
                    end else if (ex_mem_blocked[i] && !m_hd[t]) begin
                        found = 1; e[t].vld = 1; e[t].seq = ex_seq[i]; e[t].npc = ex_pc[i];
                        e[t].incl = 1; set[t] = 1;
                    end
                end
            end
        end
        e_done = ex_valid & ex_squashed;
        m_hd = (m_hd & ~blk_rearm) | set;
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < T; t++) begin
            chk(tag, "valid", sq_valid[t], e[t].vld);
            chk(tag, "seq", sq_seq[t], e[t].seq);
            chk(tag, "next_pc", sq_next_pc[t], e[t].npc);
            chk(tag, "mis_pc", sq_mis_pc[t], e[t].mpc);
            chk(tag, "branch", sq_branch[t], e[t].brmis);
            chk(tag, "taken", sq_taken[t], e[t].taken);
            chk(tag, "incl", sq_incl[t], e[t].incl);
        end
        chk("R6", "handled", blk_handled, m_hd);
        chk("R8", "ex_done", ex_done, e_done);
        chk("R7", "cnt_taken_wrong", cnt_taken_wrong, m_tw);
        chk("R7", "cnt_ntaken_wrong", cnt_ntaken_wrong, m_nw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        put(0, 0, 9, 'h10, 'h40, 1, 1, 0, 0, 0);   // activity during reset
        repeat (3) @(negedge clk);
        // R1: reset clears everything
        chk("R1", "sq_valid", sq_valid, 0);
        chk("R1", "handled", blk_handled, 0);
        chk("R1", "ex_done", ex_done, 0);
        chk("R1", "counters", {cnt_taken_wrong, cnt_ntaken_wrong}, 0);
        rst = 1'b0;
        clear_in();

        // R4: mispredict, resolved not taken (predicted taken)
        put(0, 0, 5, 'h100, 'h104, 1, 1, 0, 0, 0); step("R4");
        // R4: mispredict, resolved taken (predicted not taken), on thread 1
        clear_in(); put(2, 1, 6, 'h200, 'h380, 0, 1, 0, 0, 0); step("R4");
        // R3: all three events on one slot -> branch wins
        clear_in(); put(1, 0, 7, 'h300, 'h304, 0, 1, 1, 1, 0); step("R3");
        // R3: ordering beats blocked load
        clear_in(); put(0, 1, 8, 'h310, 'h314, 0, 0, 1, 1, 0); step("R3");
        // R5: ordering alone
        clear_in(); put(3, 0, 9, 'h320, 'h324, 1, 0, 1, 0, 0); step("R5");
        // R6: blocked load squashes itself, then is ignored, then re-armed
        clear_in(); put(0, 0, 10, 'h400, 'h404, 0, 0, 0, 1, 0); step("R6");
        clear_in(); put(0, 0, 11, 'h410, 'h414, 0, 0, 0, 1, 0); step("R6");
        clear_in(); blk_rearm = 2'b01; step("R6");
        clear_in(); put(1, 0, 12, 'h420, 'h424, 0, 0, 0, 1, 0); step("R6");
        // R2: oldest event per thread, threads independent
        clear_in();
        put(0, 1, 20, 'h500, 'h504, 0, 0, 0, 0, 0);
        put(1, 0, 21, 'h510, 'h600, 0, 0, 1, 0, 0);
        put(2, 0, 22, 'h520, 'h524, 1, 1, 0, 0, 0);
        put(3, 1, 23, 'h530, 'h534, 1, 1, 0, 0, 0);
        step("R2");
        // R8: squashed slot with a mispredict is done, younger slot acts
        clear_in();
        put(0, 0, 30, 'h700, 'h800, 1, 1, 1, 1, 1);
        put(1, 0, 31, 'h710, 'h714, 0, 0, 1, 0, 0);
        step("R8");
        // R10: invalid slots ignored
        clear_in(); ex_mispred = '1; ex_ord_viol = '1; ex_mem_blocked = '1; step("R10");
        // R9: idle cycle after activity returns to zero
        clear_in(); step("R9");

        // R2: near-exhaustive mixed sweep
        for (int n = 0; n < 4000; n++) begin
            clear_in();
            for (int i = 0; i < W; i++) begin
                if ($urandom % 4 != 0)
                    put(i, int'($urandom % T), int'($urandom % 256), int'($urandom % 65536),
                        ($urandom % 2) ? int'($urandom % 65536) : -1,
                        bit'($urandom % 2), ($urandom % 5 == 0), ($urandom % 5 == 0),
                        ($urandom % 3 == 0), ($urandom % 6 == 0));
                if (ex_valid[i] && ex_npc[i] == 16'hFFFF) ex_npc[i] = ex_pc[i] + 16'd4;
            end
            blk_rearm = T'($urandom % 8 == 0 ? $urandom : 0);
            step("R2");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule